// File: doc/BRIEF.md
# Multi-Channel Programmable CRC Engine

This block folds the data bytes of a memory move into a cyclic redundancy check. The polynomial, initial value, final XOR mask, width (8, 16 or 32 bits) and bit order are all programmable. A move opens with a start strobe. The strobe carries a channel number and a set of mode flags, and the configuration inputs are captured on that same edge. Data then arrives as a valid/ready stream of beats. Each beat carries one or two bytes, and the lower byte is the earlier one in the stream. A close strobe ends the move, and one cycle later the engine presents the finished CRC. With it come the number of bytes to append and whether the destination memory is written at all.

Every channel owns a saved sum. A move that does not request a fresh start resumes from the value that channel saved last. One CRC can therefore cover a message that is split across several moves, and moves on other channels can run in between. Polynomial, initial value and XOR mask are always given left-justified in 32-bit fields. A 16-bit CRC with polynomial 0x8005, for example, is written as 0x80050000.

Top module: `crc_mc_engine`

## Requirements
- R1: After reset, `in_ready` and `res_valid` are low and every channel's saved sum is zero. A move that does not request a fresh start therefore begins from zero.
- R2: Bit order is selected by `cfg_reflect`. With `cfg_reflect`=1, each byte is folded least-significant bit first and the 32-bit result is bit-reversed. In this mode, polynomial 0x04C11DB7 with init and XOR both 0xFFFFFFFF yields 0xCBF43926 over the ASCII string "123456789", and polynomial 0x1EDC6F41 yields 0xE3069283.
- R3: The width is coded in `cfg_width` as 0 for 8 bits, 1 for 16 and 2 (or 3) for 32. Narrow results are right-justified in `res_crc`. Over "123456789" with no reflection and zero init and XOR, polynomial field 0x80050000 at width 16 gives 0xFEE8, and field 0x07000000 at width 8 gives 0xF4.
- R4: `in_ready` stays high for the whole of an open move, so a beat is accepted in every cycle. A beat folds 1 or 2 bytes, as given by `in_cnt`, which means a 32-byte move is absorbed in 16 beats.
- R5: A move with `mv_reset`=1 starts from the masked init value. A move with `mv_reset`=0 starts from the channel's saved sum. A message split across several moves therefore gives the same CRC as one move over the whole message.
- R6: Saved sums are per channel. Moves on other channels between two parts of a message leave its result unchanged.
- R7: At every close, the channel's saved sum is rewritten. If `mv_append` or `mv_xbit` is set, the value written is the finished CRC, after XOR, reversal and justification. Otherwise it is the raw running value. `res_bytes` is 1, 2 or 4 (the width divided by 8) when `mv_append` is set, and 0 otherwise.
- R8: When `mv_zero` is set, every accepted byte is folded as 0x00, whatever `in_data` holds.
- R9: `res_wr_mem` is 1 unless `mv_prefetch` is set. With `mv_prefetch` set, it is 1 only when `mv_append` is also set, and this holds even when `mv_zero` is set.
- R10: A start strobe that arrives while a move is open is ignored, together with its channel and flags.
- R11: `res_valid` pulses for exactly one cycle, in the cycle after a close strobe that was accepted. It arrives together with `res_crc`, `res_bytes` and `res_wr_mem` for that move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | CRC width code: 0 = 8, 1 = 16, 2/3 = 32 |
| cfg_poly | input | 32 | Polynomial, left-justified |
| cfg_init | input | 32 | Initial value, left-justified |
| cfg_xor | input | 32 | Final XOR mask, left-justified |
| cfg_reflect | input | 1 | Bytes folded LSB first and result reversed |
| mv_start | input | 1 | Opens a move (taken only when idle) |
| mv_chan | input | 2 | Channel of the move |
| mv_reset | input | 1 | Start from init instead of the saved sum |
| mv_append | input | 1 | CRC is appended to the destination |
| mv_xbit | input | 1 | Save the finished CRC without appending |
| mv_prefetch | input | 1 | No data is moved |
| mv_zero | input | 1 | Fold zeros in place of data |
| in_valid | input | 1 | Data beat valid |
| in_cnt | input | 2 | Bytes in the beat (1 or 2) |
| in_data | input | 16 | Beat data; low byte first |
| in_ready | output | 1 | Engine accepts beats (move open) |
| mv_end | input | 1 | Closes the open move |
| res_valid | output | 1 | Result pulse |
| res_crc | output | 32 | Finished CRC, right-justified |
| res_bytes | output | 3 | CRC bytes to append |
| res_wr_mem | output | 1 | Destination memory is written |

## Verification
The hardest case to reach is one where a saved sum must survive while other traffic runs. A message is split across two moves on one channel, and a move on another channel, with a different configuration, runs in between. A start strobe is also sent in the middle of an open move, carrying the other reset polarity and a different channel. The directed sequences build both cases on purpose. The random phase then mixes widths, flags, channels and byte splits, and resumes channels whose last save was a finished value, so the saved-sum path is exercised in every mode.

// File: rtl/crc_mc_pkg.sv
package crc_mc_pkg;

  typedef enum logic [1:0] {
    CRCW_8   = 2'd0,
    CRCW_16  = 2'd1,
    CRCW_32  = 2'd2,
    CRCW_32B = 2'd3
  } crc_width_e;

  // Mask of the live bits of a left-justified value.
  function automatic logic [31:0] width_mask(crc_width_e w);
    case (w)
      CRCW_8:  width_mask = 32'hFF00_0000;
      CRCW_16: width_mask = 32'hFFFF_0000;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Shift that right-justifies a left-justified value.
  function automatic logic [4:0] width_shift(crc_width_e w);
    case (w)
      CRCW_8:  width_shift = 5'd24;
      CRCW_16: width_shift = 5'd16;
      default: width_shift = 5'd0;
    endcase
  endfunction

  function automatic logic [2:0] width_bytes(crc_width_e w);
    case (w)
      CRCW_8:  width_bytes = 3'd1;
      CRCW_16: width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/crc_mc_lane.sv
// Folds one byte into a left-justified 32-bit running CRC.
module crc_mc_lane (
  input  logic [31:0] state_i,
  input  logic [7:0]  byte_i,
  input  logic        en_i,
  input  logic [31:0] poly_i,
  input  logic        reflect_i,
  output logic [31:0] state_o
);
  logic [31:0] acc;
  logic        din;
  logic        fb;

  always_comb begin
    acc = state_i;
    din = 1'b0;
    fb  = 1'b0;
    for (int b = 0; b < 8; b++) begin
      din = reflect_i ? byte_i[b] : byte_i[7-b];
      fb  = acc[31] ^ din;
      acc = {acc[30:0], 1'b0} ^ (fb ? poly_i : 32'h0);
    end
    state_o = en_i ? acc : state_i;
  end
endmodule

// File: rtl/crc_mc_finish.sv
// Applies the final XOR, then reverses (reflected) or right-justifies.
module crc_mc_finish
  import crc_mc_pkg::*;
(
  input  logic [31:0] state_i,
  input  logic [31:0] xor_i,
  input  logic        reflect_i,
  input  crc_width_e  width_i,
  output logic [31:0] crc_o
);
  logic [31:0] mixed;
  logic [31:0] rev;

  always_comb begin
    mixed = state_i ^ xor_i;
    for (int i = 0; i < 32; i++) rev[i] = mixed[31-i];
    crc_o = reflect_i ? rev : (mixed >> width_shift(width_i));
  end
endmodule

// File: rtl/crc_mc_psum.sv
// Per-channel saved sums.
module crc_mc_psum #(
  parameter int CHANNELS = 4,
  localparam int CHW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_chan,
  input  logic [31:0]    wr_data,
  input  logic [CHW-1:0] rd_chan,
  output logic [31:0]    rd_data
);
  logic [31:0] sum_q [CHANNELS];

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    logic        hit;
    logic [31:0] sum_d;
    always_comb begin
      hit   = wr_en && (wr_chan == CHW'(g));
      sum_d = hit ? wr_data : sum_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q[g] <= 32'h0;
      else        sum_q[g] <= sum_d;
    end
  end

  assign rd_data = sum_q[rd_chan];
endmodule

// File: rtl/crc_mc_engine.sv
module crc_mc_engine
  import crc_mc_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int CHANNELS = 4,
  localparam int CHW  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int DW   = 8 * LANES,
  localparam int CNTW = $clog2(LANES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_width,
  input  logic [31:0]     cfg_poly,
  input  logic [31:0]     cfg_init,
  input  logic [31:0]     cfg_xor,
  input  logic            cfg_reflect,
  input  logic            mv_start,
  input  logic [CHW-1:0]  mv_chan,
  input  logic            mv_reset,
  input  logic            mv_append,
  input  logic            mv_xbit,
  input  logic            mv_prefetch,
  input  logic            mv_zero,
  input  logic            in_valid,
  input  logic [CNTW-1:0] in_cnt,
  input  logic [DW-1:0]   in_data,
  output logic            in_ready,
  input  logic            mv_end,
  output logic            res_valid,
  output logic [31:0]     res_crc,
  output logic [2:0]      res_bytes,
  output logic            res_wr_mem
);
  // Move context, captured at start
  logic           busy_q, busy_d;
  logic [CHW-1:0] chan_q, chan_d;
  logic           append_q, append_d, xbit_q, xbit_d;
  logic           pref_q, pref_d, zero_q, zero_d;
  logic           refl_q, refl_d;
  crc_width_e     width_q, width_d;
  logic [31:0]    poly_q, poly_d, xor_q, xor_d;
  logic [31:0]    state_q, state_d;
  // Result registers
  logic           rv_q, rv_d, rwr_q, rwr_d;
  logic [31:0]    rcrc_q, rcrc_d;
  logic [2:0]     rbytes_q, rbytes_d;

  logic        start_ok, beat, close_ok;
  logic [31:0] psum_rd, psum_wd, finished, folded;
  logic [31:0] stage [LANES+1];
  crc_width_e  cfg_w;

  assign cfg_w    = crc_width_e'(cfg_width);
  assign start_ok = mv_start && !busy_q;
  assign beat     = in_valid && busy_q;
  assign close_ok = mv_end && busy_q;

  // Unrolled byte lanes, chained low byte first
  assign stage[0] = state_q;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       lane_en;
    logic [7:0] lane_byte;
    assign lane_en   = beat && (CNTW'(l) < in_cnt);
    assign lane_byte = zero_q ? 8'h00 : in_data[8*l +: 8];
    crc_mc_lane u_lane (
      .state_i  (stage[l]),
      .byte_i   (lane_byte),
      .en_i     (lane_en),
      .poly_i   (poly_q),
      .reflect_i(refl_q),
      .state_o  (stage[l+1])
    );
  end
  assign folded = stage[LANES];

  crc_mc_finish u_finish (
    .state_i  (folded),
    .xor_i    (xor_q),
    .reflect_i(refl_q),
    .width_i  (width_q),
    .crc_o    (finished)
  );

  assign psum_wd = (append_q || xbit_q) ? finished : folded;

  crc_mc_psum #(.CHANNELS(CHANNELS)) u_psum (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (close_ok),
    .wr_chan(chan_q),
    .wr_data(psum_wd),
    .rd_chan(mv_chan),
    .rd_data(psum_rd)
  );

  // Next-state logic
  always_comb begin
    busy_d   = busy_q;
    chan_d   = chan_q;
    append_d = append_q;
    xbit_d   = xbit_q;
    pref_d   = pref_q;
    zero_d   = zero_q;
    refl_d   = refl_q;
    width_d  = width_q;
    poly_d   = poly_q;
    xor_d    = xor_q;
    state_d  = state_q;
    rv_d     = close_ok;
    rcrc_d   = rcrc_q;
    rbytes_d = rbytes_q;
    rwr_d    = rwr_q;
    if (start_ok) begin
      busy_d   = 1'b1;
      chan_d   = mv_chan;
      append_d = mv_append;
      xbit_d   = mv_xbit;
      pref_d   = mv_prefetch;
      zero_d   = mv_zero;
      refl_d   = cfg_reflect;
      width_d  = cfg_w;
      poly_d   = cfg_poly & width_mask(cfg_w);
      xor_d    = cfg_xor & width_mask(cfg_w);
      state_d  = mv_reset ? (cfg_init & width_mask(cfg_w)) : psum_rd;
    end else if (busy_q) begin
      state_d = folded;
      if (close_ok) begin
        busy_d   = 1'b0;
        rcrc_d   = finished;
        rbytes_d = append_q ? width_bytes(width_q) : 3'd0;
        rwr_d    = !pref_q || append_q;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      chan_q   <= '0;
      append_q <= 1'b0;
      xbit_q   <= 1'b0;
      pref_q   <= 1'b0;
      zero_q   <= 1'b0;
      refl_q   <= 1'b0;
      width_q  <= CRCW_32;
      poly_q   <= 32'h0;
      xor_q    <= 32'h0;
      state_q  <= 32'h0;
      rv_q     <= 1'b0;
      rcrc_q   <= 32'h0;
      rbytes_q <= 3'd0;
      rwr_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      chan_q   <= chan_d;
      append_q <= append_d;
      xbit_q   <= xbit_d;
      pref_q   <= pref_d;
      zero_q   <= zero_d;
      refl_q   <= refl_d;
      width_q  <= width_d;
      poly_q   <= poly_d;
      xor_q    <= xor_d;
      state_q  <= state_d;
      rv_q     <= rv_d;
      rcrc_q   <= rcrc_d;
      rbytes_q <= rbytes_d;
      rwr_q    <= rwr_d;
    end
  end

  assign in_ready   = busy_q;
  assign res_valid  = rv_q;
  assign res_crc    = rcrc_q;
  assign res_bytes  = rbytes_q;
  assign res_wr_mem = rwr_q;
endmodule

// File: rtl/crc_mc_engine_chk.sv
module crc_mc_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mv_start,
  input logic       mv_end,
  input logic       in_ready,
  input logic       res_valid,
  input logic [2:0] res_bytes,
  input logic       res_wr_mem
);
  // R11
  close_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_end && in_ready) |=> res_valid);

  // R11
  result_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R11
  idle_after_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  // R4
  start_opens_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_start && !in_ready) |=> in_ready);

  // R4
  open_until_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !mv_end) |=> in_ready);

  // R7
  append_size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_bytes) <= 1 && res_bytes != 3'd0 || res_bytes == 3'd0));

  // R9
  no_write_no_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_wr_mem) |-> (res_bytes == 3'd0));
endmodule

bind crc_mc_engine crc_mc_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mv_start  (mv_start),
  .mv_end    (mv_end),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_bytes (res_bytes),
  .res_wr_mem(res_wr_mem)
);

// File: tb/crc_mc_engine_bench.sv
`timescale 1ns/1ps
module crc_mc_engine_bench;
  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_width;
  logic [31:0] cfg_poly, cfg_init, cfg_xor;
  logic        cfg_reflect;
  logic        mv_start;
  logic [1:0]  mv_chan;
  logic        mv_reset, mv_append, mv_xbit, mv_prefetch, mv_zero;
  logic        in_valid;
  logic [1:0]  in_cnt;
  logic [15:0] in_data;
  logic        in_ready;
  logic        mv_end;
  logic        res_valid;
  logic [31:0] res_crc;
  logic [2:0]  res_bytes;
  logic        res_wr_mem;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  mbuf [0:63];
  logic [31:0] mpsum [0:3];

  crc_mc_engine u_crc_mc_engine (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R4 R11): act=hung exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_mask(input logic [1:0] w);
    return (w == 2'd0) ? 32'hFF000000 : (w == 2'd1) ? 32'hFFFF0000 : 32'hFFFFFFFF;
  endfunction

  function automatic logic [31:0] m_byte(input logic [31:0] c, input logic [7:0] d,
                                         input logic [31:0] p, input logic refl);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = refl ? d[7-i] : d[i];
    c = c ^ {o, 24'h0};
    for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ p) : (c << 1);
    return c;
  endfunction

  function automatic logic [31:0] m_final(input logic [31:0] c, input logic [31:0] x,
                                          input logic refl, input logic [1:0] w);
    logic [31:0] v, r;
    v = c ^ x;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    if (refl) return r;
    return (w == 2'd0) ? (v >> 24) : (w == 2'd1) ? (v >> 16) : v;
  endfunction

  task automatic load_str(input string s);
    for (int i = 0; i < s.len(); i++) mbuf[i] = s[i];
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic [31:0] p, input logic [31:0] ini,
                         input logic [31:0] x, input logic refl);
    cfg_width = w; cfg_poly = p; cfg_init = ini; cfg_xor = x; cfg_reflect = refl;
  endtask

  task automatic do_move(input int ch, input bit rs, input bit ap, input bit xb,
                         input bit pf, input bit zr, input int len, input bit pairs,
                         input bit spur, input string req);
    logic [31:0] m, fin, mk;
    logic [2:0]  eb;
    int i, n, beats;
    mk = m_mask(cfg_width);
    m = rs ? (cfg_init & mk) : mpsum[ch];
    for (int j = 0; j < len; j++) m = m_byte(m, zr ? 8'h00 : mbuf[j], cfg_poly & mk, cfg_reflect);
    fin = m_final(m, cfg_xor & mk, cfg_reflect, cfg_width);
    mpsum[ch] = (ap || xb) ? fin : m;
    eb = !ap ? 3'd0 : (cfg_width == 2'd0) ? 3'd1 : (cfg_width == 2'd1) ? 3'd2 : 3'd4;

    @(negedge clk);
    mv_start = 1'b1; mv_chan = 2'(ch); mv_reset = rs; mv_append = ap;
    mv_xbit = xb; mv_prefetch = pf; mv_zero = zr;
    @(negedge clk);
    mv_start = 1'b0;
    i = 0; beats = 0;
    while (i < len) begin
      n = ((pairs || ($urandom % 2) == 1) && (i + 1 < len)) ? 2 : 1;
      in_valid = 1'b1;
      in_cnt   = 2'(n);
      in_data  = {(n == 2) ? mbuf[i+1] : 8'($urandom), mbuf[i]};
      if (spur && i == 0) begin
        mv_start = 1'b1; mv_chan = 2'(ch ^ 1); mv_reset = !rs; mv_zero = !zr;
      end
      check({req, " R4 ready in move"}, {31'h0, in_ready}, 32'h1);
      @(negedge clk);
      mv_start = 1'b0;
      i += n; beats++;
    end
    in_valid = 1'b0;
    if (pairs) check({req, " R4 beat count"}, beats, (len + 1) / 2);
    mv_end = 1'b1;
    @(negedge clk);
    mv_end = 1'b0;
    check({req, " R11 res_valid"}, {31'h0, res_valid}, 32'h1);
    check({req, " crc"}, res_crc, fin);
    check({req, " R7 res_bytes"}, {29'h0, res_bytes}, {29'h0, eb});
    check({req, " R9 res_wr_mem"}, {31'h0, res_wr_mem}, {31'h0, (!pf || ap)});
    @(negedge clk);
    check({req, " R11 pulse ends"}, {31'h0, res_valid}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_C0DE));
    for (int c = 0; c < 4; c++) mpsum[c] = 32'h0;
    rst_n = 1'b0; mv_start = 0; mv_chan = 0; mv_reset = 0; mv_append = 0; mv_xbit = 0;
    mv_prefetch = 0; mv_zero = 0; in_valid = 0; in_cnt = 0; in_data = 0; mv_end = 0;
    set_cfg(2'd2, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 in_ready after reset", {31'h0, in_ready}, 32'h0);
    check("R1 res_valid after reset", {31'h0, res_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty move from saved sum zero
    do_move(0, 0, 0, 0, 0, 0, 0, 1, 0, "R1 empty from zero sum");
    check("R1 zero sum finish", res_crc, 32'hFFFFFFFF);

    // R2: reflected CRC-32 variants
    load_str("123456789");
    do_move(0, 1, 1, 1, 0, 0, 9, 1, 0, "R2 ethernet");
    check("R2 ethernet known", res_crc, 32'hCBF43926);
    set_cfg(2'd2, 32'h1EDC6F41, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    do_move(1, 1, 1, 1, 0, 0, 9, 0, 0, "R2 castagnoli");
    check("R2 castagnoli known", res_crc, 32'hE3069283);

    // R3: narrow, non-reflected
    set_cfg(2'd1, 32'h80050000, 32'h0, 32'h0, 1'b0);
    do_move(2, 1, 0, 0, 0, 0, 9, 1, 0, "R3 16-bit");
    check("R3 16-bit known", res_crc, 32'h0000FEE8);
    set_cfg(2'd0, 32'h07000000, 32'h0, 32'h0, 1'b0);
    do_move(3, 1, 1, 0, 0, 0, 9, 0, 0, "R3 8-bit");
    check("R3 8-bit known", res_crc, 32'h000000F4);

    // R5 / R6: split message with a foreign move in between
    set_cfg(2'd2, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    load_str("1234");
    do_move(2, 1, 0, 0, 1, 0, 4, 0, 0, "R5 first part");
    set_cfg(2'd1, 32'h80050000, 32'h0, 32'h0, 1'b0);
    load_str("zzzzzz");
    do_move(3, 1, 1, 0, 0, 0, 6, 0, 0, "R6 other channel");
    set_cfg(2'd2, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    load_str("56789");
    do_move(2, 0, 1, 0, 0, 0, 5, 0, 0, "R5 second part");
    check("R5 R6 split equals whole", res_crc, 32'hCBF43926);

    // R8 / R4: full 32-byte line of zeros in place of data
    for (int k = 0; k < 32; k++) mbuf[k] = 8'($urandom | 1);
    do_move(0, 1, 0, 0, 0, 1, 32, 1, 0, "R8 zero fill line");
    // R9: prefetch modes
    do_move(1, 1, 0, 0, 1, 1, 8, 1, 0, "R9 prefetch zero no append");
    do_move(1, 1, 1, 0, 1, 1, 8, 1, 0, "R9 prefetch zero append");
    do_move(1, 1, 0, 0, 1, 0, 8, 0, 0, "R9 prefetch only");

    // R10: stray start during an open move
    load_str("123456789");
    do_move(0, 1, 1, 0, 0, 0, 9, 1, 1, "R10 stray start");
    check("R10 result unaffected", res_crc, 32'hCBF43926);

    // R7: extra-bit save then resume from the finished value
    do_move(1, 1, 0, 1, 0, 0, 9, 0, 0, "R7 xbit save");
    do_move(1, 0, 0, 0, 0, 0, 3, 0, 0, "R7 resume finished");

    // Random mix
    for (int r = 0; r < 60; r++) begin
      logic [1:0] w;
      w = 2'($urandom % 4);
      set_cfg(w, $urandom, $urandom, $urandom, 1'($urandom));
      for (int k = 0; k < 40; k++) mbuf[k] = 8'($urandom);
      do_move(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), int'($urandom % 40), 1'($urandom),
              ($urandom % 8) == 0, "R5 R7 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule